// File: doc/BRIEF.md
# Multi-Stream Allocation Table Commit Unit

This block holds the time-slot allocation table of a multi-stream display link. The table has four entries, and each entry names a source stream and the number of time slots it owns. Software never writes the live table. It fills a shadow copy through a small register window. It then writes an update command. The block moves the shadow copy into the active table at a frame boundary, so the slot scheduler downstream never sees a half-written table.

Two commit flavours exist. In the first, the block asks the link layer for an allocation-change trigger, waits for that request to be acknowledged, and commits at the following frame boundary. In the second, it skips the trigger and commits at the next frame boundary. Once a commit lands, a keepout flag stays high until sixteen multi-stream transport packet headers have gone out. Software polls the update field and the keepout flag and may start a new change only when both read zero. Entries that are not in use are written as source 0 with 0 slots, which is also the reset content.

Top module: `mst_alloc_commit`

## Requirements
- R1: After reset, every active entry reads source 0 and slot count 0, and `upd_state`, `keepout` and `trig_req` are all 0.
- R2: Register writes at `wr_addr` 0 set shadow entries 0 and 1, and writes at address 1 set entries 2 and 3. The even entry sits in `wr_data[9:0]` and the odd entry in `wr_data[25:16]`. In each entry, bits [5:0] hold the slot count and bits [9:6] hold the source. Shadow writes leave the active table unchanged until a commit.
- R3: Writing code 1 to the update field (`wr_addr` 2, `wr_data[1:0]`) while idle makes `upd_state` read 1. It also raises `trig_req` for exactly the one cycle that follows the write.
- R4: For code 1, the commit happens at the first `frame_strobe` seen strictly after the cycle in which `trig_ack` is high. A frame strobe before the acknowledge, or in the same cycle as it, does not commit.
- R5: Writing code 2 while idle makes `upd_state` read 2 and raises no trigger request. The commit happens at the next `frame_strobe`.
- R6: On a commit, the active table takes the shadow content and `upd_state` returns to 0 at the same clock edge. While `upd_state` is 0 the active table does not change.
- R7: Update-field writes while an update is pending do not change `upd_state` or raise a trigger request. Codes 0 and 3 written while idle have no effect.
- R8: `keepout` goes to 1 at the commit edge. It returns to 0 at the edge that counts the sixteenth `mtp_strobe` after the commit. A header strobe in the commit cycle itself is not counted.
- R9: A new update command is accepted while `keepout` is still 1. Its commit restarts the sixteen-header count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 and 1 for shadow pairs, 2 for the update field |
| wr_data | input | 32 | Register write data |
| trig_ack | input | 1 | Acknowledge of the allocation-change trigger |
| frame_strobe | input | 1 | One-cycle frame boundary marker |
| mtp_strobe | input | 1 | One-cycle marker for each transport packet header sent |
| trig_req | output | 1 | One-cycle allocation-change trigger request |
| upd_state | output | 2 | Update field readback: 0 idle, 1 or 2 pending code |
| keepout | output | 1 | High from a commit until sixteen headers have been sent |
| active_src | output | 16 | Active source IDs, entry e at bits [4e+3:4e] |
| active_slots | output | 24 | Active slot counts, entry e at bits [6e+5:6e] |

## Verification
The commit and the keepout counter can act in the same cycle. The bench drives `frame_strobe` and `mtp_strobe` together in the committing cycle and expects exactly sixteen further headers before `keepout` falls, because the header in the commit cycle must not count. The acknowledge and the frame boundary also meet: `trig_ack` and `frame_strobe` are raised in one cycle, and the table must stay unchanged until a later frame strobe. A third collision is a new commit that lands while an earlier keepout window is still running. The bench expects the count to restart from zero.

// File: rtl/mst_alloc_pkg.sv
package mst_alloc_pkg;
   localparam int REG_DATA_W = 32;
   localparam int HALF_W     = 16;

   typedef enum logic [1:0] {
      UPD_NONE   = 2'd0,
      UPD_TRIG   = 2'd1,
      UPD_NOTRIG = 2'd2
   } upd_code_e;

   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_WAIT_ACK   = 2'd1,
      ST_WAIT_FRAME = 2'd2
   } commit_st_e;
endpackage

// File: rtl/alloc_shadow_regs.sv
module alloc_shadow_regs
   import mst_alloc_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ENTRY_W     = 10,
   parameter int ADDR_W      = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [REG_DATA_W-1:0]          wr_data,
   output logic [NUM_ENTRIES*ENTRY_W-1:0] shadow_flat
);
   if (ENTRY_W > HALF_W) begin : g_bad_entry_w
      $error("shadow entry wider than half a register");
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      localparam int PAIR = e / 2;
      localparam int LSB  = (e % 2) * HALF_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_flat[e*ENTRY_W +: ENTRY_W] <= '0;
         end else if (wr_en && wr_addr == ADDR_W'(PAIR)) begin
            shadow_flat[e*ENTRY_W +: ENTRY_W] <= wr_data[LSB +: ENTRY_W];
         end
      end
   end
endmodule

// File: rtl/alloc_commit_fsm.sv
module alloc_commit_fsm
   import mst_alloc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [1:0] cmd_code,
   input  logic       trig_ack,
   input  logic       frame_strobe,
   output logic       trig_req,
   output logic       commit,
   output logic [1:0] upd_code
);
   commit_st_e state;

   assign commit = (state == ST_WAIT_FRAME) && frame_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         trig_req <= 1'b0;
         upd_code <= UPD_NONE;
      end else begin
         trig_req <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cmd_wr && cmd_code == UPD_TRIG) begin
                  state    <= ST_WAIT_ACK;
                  trig_req <= 1'b1;
                  upd_code <= UPD_TRIG;
               end else if (cmd_wr && cmd_code == UPD_NOTRIG) begin
                  state    <= ST_WAIT_FRAME;
                  upd_code <= UPD_NOTRIG;
               end
            end
            ST_WAIT_ACK: begin
               if (trig_ack) state <= ST_WAIT_FRAME;
            end
            ST_WAIT_FRAME: begin
               if (frame_strobe) begin
                  state    <= ST_IDLE;
                  upd_code <= UPD_NONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_req |=> !trig_req); // R3
   AST_TRIG_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      trig_req |-> $past(cmd_wr && cmd_code == UPD_TRIG)); // R3
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_code != UPD_NONE && cmd_wr && !frame_strobe) |=> $stable(upd_code)); // R7
   AST_NOTRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_code == UPD_NOTRIG) |-> !trig_req); // R5
endmodule

// File: rtl/alloc_keepout_ctr.sv
module alloc_keepout_ctr #(
   parameter int KEEPOUT_MTPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mtp_strobe,
   output logic keepout
);
   localparam int CNT_W = $clog2(KEEPOUT_MTPS + 1);

   if (KEEPOUT_MTPS < 1) begin : g_bad_count
      $error("keepout count must be at least one");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keepout <= 1'b0;
         cnt     <= '0;
      end else if (start) begin
         keepout <= 1'b1;
         cnt     <= '0;
      end else if (keepout && mtp_strobe) begin
         if (cnt == CNT_W'(KEEPOUT_MTPS - 1)) begin
            keepout <= 1'b0;
            cnt     <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_KEEPOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (keepout && !mtp_strobe) |=> keepout); // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(KEEPOUT_MTPS)); // R8
endmodule

// File: rtl/alloc_active_table.sv
module alloc_active_table #(
   parameter int NUM_ENTRIES = 4,
   parameter int ENTRY_W     = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic [NUM_ENTRIES*ENTRY_W-1:0] shadow_flat,
   output logic [NUM_ENTRIES*ENTRY_W-1:0] active_flat
);
   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_flat[e*ENTRY_W +: ENTRY_W] <= '0;
         end else if (load) begin
            active_flat[e*ENTRY_W +: ENTRY_W] <= shadow_flat[e*ENTRY_W +: ENTRY_W];
         end
      end
   end
endmodule

// File: rtl/mst_alloc_commit.sv
module mst_alloc_commit
   import mst_alloc_pkg::*;
#(
   parameter int NUM_ENTRIES  = 4,
   parameter int SRC_W        = 4,
   parameter int SLOT_W       = 6,
   parameter int ADDR_W       = 2,
   parameter int KEEPOUT_MTPS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [REG_DATA_W-1:0]         wr_data,
   input  logic                          trig_ack,
   input  logic                          frame_strobe,
   input  logic                          mtp_strobe,
   output logic                          trig_req,
   output logic [1:0]                    upd_state,
   output logic                          keepout,
   output logic [NUM_ENTRIES*SRC_W-1:0]  active_src,
   output logic [NUM_ENTRIES*SLOT_W-1:0] active_slots
);
   localparam int ENTRY_W  = SRC_W + SLOT_W;
   localparam int CMD_ADDR = NUM_ENTRIES / 2;

   if (NUM_ENTRIES % 2 != 0) begin : g_bad_entries
      $error("entry count must be even");
   end
   if (CMD_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("address width too small for update field");
   end

   logic [NUM_ENTRIES*ENTRY_W-1:0] shadow_flat;
   logic [NUM_ENTRIES*ENTRY_W-1:0] active_flat;
   logic                           cmd_wr;
   logic                           commit;

   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));

   alloc_shadow_regs #(
      .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)
   ) i_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .shadow_flat(shadow_flat)
   );

   alloc_commit_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(wr_data[1:0]),
      .trig_ack(trig_ack), .frame_strobe(frame_strobe),
      .trig_req(trig_req), .commit(commit), .upd_code(upd_state)
   );

   alloc_active_table #(
      .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)
   ) i_active (
      .clk(clk), .rst_n(rst_n), .load(commit),
      .shadow_flat(shadow_flat), .active_flat(active_flat)
   );

   alloc_keepout_ctr #(
      .KEEPOUT_MTPS(KEEPOUT_MTPS)
   ) i_keepout (
      .clk(clk), .rst_n(rst_n), .start(commit),
      .mtp_strobe(mtp_strobe), .keepout(keepout)
   );

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_split
      assign active_slots[e*SLOT_W +: SLOT_W] = active_flat[e*ENTRY_W +: SLOT_W];
      assign active_src[e*SRC_W +: SRC_W]     = active_flat[e*ENTRY_W + SLOT_W +: SRC_W];
   end

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_state == 2'd0) |=> ($stable(active_src) && $stable(active_slots))); // R6
   AST_KEEPOUT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upd_state != 2'd0) && upd_state == 2'd0) |-> keepout); // R8
endmodule

// File: tb/test_mst_alloc_commit.sv
module test_mst_alloc_commit;
   localparam int NE = 4;
   localparam int SW = 4;
   localparam int LW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic trig_ack = 1'b0;
   logic frame_strobe = 1'b0;
   logic mtp_strobe = 1'b0;
   logic trig_req;
   logic [1:0] upd_state;
   logic keepout;
   logic [NE*SW-1:0] active_src;
   logic [NE*LW-1:0] active_slots;

   int checks = 0;
   int errors = 0;
   int exp_src [NE];
   int exp_slot[NE];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mst_alloc_commit i_mst_alloc_commit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trig_ack(trig_ack), .frame_strobe(frame_strobe),
      .mtp_strobe(mtp_strobe), .trig_req(trig_req), .upd_state(upd_state),
      .keepout(keepout), .active_src(active_src), .active_slots(active_slots)
   );

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic write_reg(int a, int d);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 32'(d);
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic check_table(string req);
      for (int e = 0; e < NE; e++) begin
         check(req, "active src", active_src[e*SW +: SW], exp_src[e]);
         check(req, "active slots", active_slots[e*LW +: LW], exp_slot[e]);
      end
   endtask

   function automatic int pat_src(int e, int k);
      return (e * 3 + k * 5 + 1) % 16;
   endfunction
   function automatic int pat_slot(int e, int k);
      return (e * 7 + k * 11 + 2) % 64;
   endfunction
   function automatic int entry_word(int e, int k);
      return (pat_src(e, k) << 6) | pat_slot(e, k);
   endfunction

   task automatic load_shadow(int k);
      for (int p = 0; p < NE / 2; p++)
         write_reg(p, (entry_word(2*p+1, k) << 16) | entry_word(2*p, k));
   endtask

   task automatic mtp_run(int n);
      for (int i = 0; i < n; i++) begin
         mtp_strobe = 1'b1; tick(); mtp_strobe = 1'b0; tick();
      end
   endtask

   task automatic pulse_frame_commit(string req, int k);
      frame_strobe = 1'b1; mtp_strobe = 1'b1; tick();
      frame_strobe = 1'b0; mtp_strobe = 1'b0;
      for (int e = 0; e < NE; e++) begin
         exp_src[e] = pat_src(e, k); exp_slot[e] = pat_slot(e, k);
      end
      check(req, "upd_state after commit", upd_state, 0);
      check_table(req);
      check("R8", "keepout at commit", keepout, 1);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < NE; e++) begin exp_src[e] = 0; exp_slot[e] = 0; end
      repeat (3) tick();
      // R1 reset state
      check("R1", "upd_state", upd_state, 0);
      check("R1", "keepout", keepout, 0);
      check("R1", "trig_req", trig_req, 0);
      check_table("R1");
      rst_n = 1'b1;
      tick();

      // R7: codes 0 and 3 in idle do nothing
      write_reg(2, 0);
      check("R7", "code 0 upd_state", upd_state, 0);
      write_reg(2, 3);
      check("R7", "code 3 upd_state", upd_state, 0);
      check("R7", "code 3 trig_req", trig_req, 0);

      for (int k = 0; k < 6; k++) begin
         load_shadow(k);
         check_table("R2");
         if (k % 2 == 0) begin
            write_reg(2, 1);
            check("R3", "upd_state pending", upd_state, 1);
            check("R3", "trig_req raised", trig_req, 1);
            write_reg(2, 2); // R7 ignored while pending
            check("R3", "trig_req one cycle", trig_req, 0);
            check("R7", "busy write upd_state", upd_state, 1);
            tick();
            check("R7", "no second trigger", trig_req, 0);
            frame_strobe = 1'b1; tick(); frame_strobe = 1'b0;
            check("R4", "frame before ack upd", upd_state, 1);
            check_table("R4");
            trig_ack = 1'b1; frame_strobe = 1'b1; tick();
            trig_ack = 1'b0; frame_strobe = 1'b0;
            check("R4", "frame with ack upd", upd_state, 1);
            check_table("R4");
            repeat (k) tick();
            pulse_frame_commit("R4", k);
         end else begin
            write_reg(2, 2);
            check("R5", "upd_state pending", upd_state, 2);
            check("R5", "no trigger", trig_req, 0);
            write_reg(2, 1);
            check("R7", "busy write upd_state", upd_state, 2);
            check("R7", "busy write trigger", trig_req, 0);
            repeat (k) tick();
            check_table("R5");
            pulse_frame_commit("R5", k);
         end
         tick();
         check("R6", "table held idle", active_src[SW-1:0], exp_src[0]);
         mtp_run(15);
         check("R8", "keepout after 15", keepout, 1);
         mtp_run(1);
         check("R8", "keepout after 16", keepout, 0);
         mtp_run(3);
         check("R8", "keepout stays low", keepout, 0);
      end

      // R9: new commit while keepout is high restarts the count
      load_shadow(7);
      write_reg(2, 2);
      pulse_frame_commit("R9", 7);
      mtp_run(10);
      check("R9", "keepout midway", keepout, 1);
      load_shadow(8);
      write_reg(2, 2);
      check("R9", "accepted under keepout", upd_state, 2);
      pulse_frame_commit("R9", 8);
      mtp_run(15);
      check("R9", "keepout restarted", keepout, 1);
      mtp_run(1);
      check("R9", "keepout cleared", keepout, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule